// File: doc/BRIEF.md
# Background Match-Bitmap Scrub Engine

This block repairs one corrupted word of a RAM-based ternary lookup table without stalling lookups. The lookup fabric is split into several partitions. Each partition is a small RAM addressed by a key chunk, and each word holds one match bit per rule plus a parity bit. When a lookup finds a parity mismatch, it reports the partition number and the key chunk that addressed the bad word. The engine then rebuilds that word from a separate, error-free table that keeps every rule chunk in value/mask form.

After it accepts a report, the engine reads the rules of the reported partition from the encoded table, one per cycle, and tests each rule against the failing key chunk. It shifts the results into a bitmap and accumulates their parity. When the last rule has been tested, it writes the bitmap and the parity into the partition RAM through that RAM's write port, at the address given by the key chunk. The partition RAMs are simple dual-port, so searches keep using the read port during the whole repair.

The engine handles one repair at a time. Reports that arrive while it is working are discarded, because a later lookup of the same word raises the report again. A report that repeats the word just written, in the first cycle after that write, is also discarded, since it comes from a lookup that read the word before the write landed.

Top module: `bitmap_scrub`

## Requirements
- R1: After synchronous reset, `busy` is 0 and every bit of `wr_en` is 0.
- R2: After a report is accepted, `tbl_addr` carries {partition, rule index} with the partition in the upper bits. It presents rule indices 0 to RULES-1, one per cycle, starting in the cycle right after acceptance. The table returns the data of an address one clock edge after that address is presented.
- R3: A rule chunk matches the failing key chunk when every bit position whose mask bit is 0 holds the same value in the key and in the rule. A mask bit of 1 makes that position don't-care.
- R4: Bit i of `wr_data` (for i from 0 to RULES-1) is the match result of rule i of the reported partition.
- R5: Bit RULES of `wr_data` is the XOR of bits RULES-1 to 0, so the written word always has an even number of ones.
- R6: `wr_en` is one-hot on bit `partition` for exactly one cycle, with `wr_addr` equal to the failing key chunk. It rises at the (RULES+1)-th rising edge after the edge that accepts the report.
- R7: `busy` rises at the edge that accepts a report, stays high through the write cycle, and is low in the cycle after the write.
- R8: A report presented while `busy` is high is discarded: it leads to no table read and no write.
- R9: In the first cycle after a write, a report that names the same partition and key chunk as that write is discarded. A report that differs in either field is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error report strobe |
| err_part | input | $clog2(N_PART) | Partition of the corrupted word |
| err_chunk | input | CHUNK_W | Key chunk that addressed the corrupted word |
| tbl_addr | output | $clog2(N_PART)+$clog2(RULES) | Encoded-table read address |
| tbl_value | input | CHUNK_W | Rule chunk value, one cycle after the address |
| tbl_mask | input | CHUNK_W | Rule chunk don't-care mask, one cycle after the address |
| wr_en | output | N_PART | Per-partition write enable |
| wr_addr | output | CHUNK_W | Write address (the failing key chunk) |
| wr_data | output | RULES+1 | Rebuilt bitmap with parity in the top bit |
| busy | output | 1 | Repair in progress |

## Verification
The bitmap rebuild is tried with four kinds of rule table. Exact rules with no don't-care bits show whether the value comparison works bit by bit. Fully masked rules must all match, which exposes any inversion of the mask sense and any parity error on an all-ones bitmap. Mixed value/mask patterns across all partitions show rule ordering, partition selection in the upper address bits, and parity on bitmaps with an odd number of ones. Reports held high during a repair, and reports repeated right after a write, separate the drop rule from the repeat filter, and both from normal back-to-back acceptance.

// File: rtl/bscrub_pkg.sv
package bscrub_pkg;

    localparam int MAX_CW = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_WRITE = 2'd2
    } scrub_st_e;

    // A rule position contributes only where its don't-care bit is clear.
    function automatic logic rule_hit(
        input logic [MAX_CW-1:0] key,
        input logic [MAX_CW-1:0] value,
        input logic [MAX_CW-1:0] dc_mask
    );
        return ((key ^ value) & ~dc_mask) == '0;
    endfunction

endpackage

// File: rtl/bscrub_ctrl.sv
module bscrub_ctrl
    import bscrub_pkg::*;
#(
    parameter int N_PART  = 4,
    parameter int CHUNK_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      err_valid_i,
    input  logic [$clog2(N_PART)-1:0] err_part_i,
    input  logic [CHUNK_W-1:0]        err_chunk_i,
    input  logic                      rd_last_i,
    output logic                      start_o,
    output logic                      busy_o,
    output logic                      wr_fire_o,
    output logic [$clog2(N_PART)-1:0] part_o,
    output logic [CHUNK_W-1:0]        chunk_o
);

    localparam int IDW = $clog2(N_PART);

    scrub_st_e          st_q, st_d;
    logic               recent_q;
    logic [IDW-1:0]     part_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic               repeat_hit;

    assign repeat_hit = recent_q && (err_part_i == part_q) && (err_chunk_i == chunk_q);
    assign start_o    = (st_q == ST_IDLE) && err_valid_i && !repeat_hit;
    assign busy_o     = (st_q != ST_IDLE);
    assign wr_fire_o  = (st_q == ST_WRITE);
    assign part_o     = part_q;
    assign chunk_o    = chunk_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (start_o)   st_d = ST_SCAN;
            ST_SCAN:  if (rd_last_i) st_d = ST_WRITE;
            ST_WRITE: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            recent_q <= 1'b0;
            part_q   <= '0;
            chunk_q  <= '0;
        end else begin
            st_q     <= st_d;
            recent_q <= (st_q == ST_WRITE);
            if (start_o) begin
                part_q  <= err_part_i;
                chunk_q <= err_chunk_i;
            end
        end
    end

    // R9: a repeat of the word just written leaves the engine idle
    assert_ignore_repeat_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && recent_q && err_valid_i && repeat_hit) |=> (st_q == ST_IDLE));

    // R8: reports during a repair do not change the captured word
    assert_drop_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && err_valid_i) |=> ($stable(part_q) && $stable(chunk_q)));

endmodule

// File: rtl/bscrub_addr_gen.sv
module bscrub_addr_gen #(
    parameter int N_PART = 4,
    parameter int RULES  = 8
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     start_i,
    input  logic [$clog2(N_PART)-1:0]                part_i,
    output logic [$clog2(N_PART)+$clog2(RULES)-1:0]  tbl_addr_o,
    output logic                                     rd_vld_o,
    output logic                                     rd_last_o
);

    localparam int               DW   = $clog2(RULES);
    localparam logic [DW-1:0]    LAST = DW'(RULES - 1);

    logic          issuing_q;
    logic [DW-1:0] idx_q;
    logic          rd_vld_q;
    logic          rd_last_q;

    assign tbl_addr_o = {part_i, idx_q};
    assign rd_vld_o   = rd_vld_q;
    assign rd_last_o  = rd_last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing_q <= 1'b0;
            idx_q     <= '0;
            rd_vld_q  <= 1'b0;
            rd_last_q <= 1'b0;
        end else begin
            rd_vld_q  <= issuing_q;
            rd_last_q <= issuing_q && (idx_q == LAST);
            if (start_i) begin
                issuing_q <= 1'b1;
                idx_q     <= '0;
            end else if (issuing_q) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST) issuing_q <= 1'b0;
            end
        end
    end

    // R2: the last table word is followed by no further reads
    assert_last_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_last_q |-> (rd_vld_q && !issuing_q));

    // R2: rule indices advance one per cycle while issuing
    assert_index_step_R2: assert property (@(posedge clk) disable iff (rst)
        (issuing_q && !start_i && idx_q != LAST) |=> (rd_vld_q && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/bscrub_vec_build.sv
module bscrub_vec_build
    import bscrub_pkg::*;
#(
    parameter int CHUNK_W = 4,
    parameter int RULES   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               take_i,
    input  logic [CHUNK_W-1:0] key_i,
    input  logic [CHUNK_W-1:0] value_i,
    input  logic [CHUNK_W-1:0] mask_i,
    output logic [RULES-1:0]   vec_o,
    output logic               par_o
);

    logic [RULES-1:0] vec_q;
    logic             par_q;
    logic             hit;

    assign hit   = rule_hit(MAX_CW'(key_i), MAX_CW'(value_i), MAX_CW'(mask_i));
    assign vec_o = vec_q;
    assign par_o = par_q;

    // Rule 0 arrives first and ends up in bit 0 after RULES shifts.
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            par_q <= 1'b0;
        end else if (clear_i) begin
            vec_q <= '0;
            par_q <= 1'b0;
        end else if (take_i) begin
            vec_q <= {hit, vec_q[RULES-1:1]};
            par_q <= par_q ^ hit;
        end
    end

    // R3: a rule whose cared bits agree with the key is recorded as a match
    assert_hit_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (take_i && !clear_i && (((key_i ^ value_i) & ~mask_i) == '0)) |=> vec_q[RULES-1]);

endmodule

// File: rtl/bitmap_scrub.sv
module bitmap_scrub #(
    parameter int N_PART  = 4,
    parameter int CHUNK_W = 4,
    parameter int RULES   = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    err_valid,
    input  logic [$clog2(N_PART)-1:0]               err_part,
    input  logic [CHUNK_W-1:0]                      err_chunk,
    output logic [$clog2(N_PART)+$clog2(RULES)-1:0] tbl_addr,
    input  logic [CHUNK_W-1:0]                      tbl_value,
    input  logic [CHUNK_W-1:0]                      tbl_mask,
    output logic [N_PART-1:0]                       wr_en,
    output logic [CHUNK_W-1:0]                      wr_addr,
    output logic [RULES:0]                          wr_data,
    output logic                                    busy
);

    localparam int IDW = $clog2(N_PART);
    localparam int DW  = $clog2(RULES);
    localparam int AW  = IDW + DW;

    logic               start;
    logic               wr_fire;
    logic               rd_vld;
    logic               rd_last;
    logic [IDW-1:0]     part_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [RULES-1:0]   vec;
    logic               par;

    bscrub_ctrl #(.N_PART(N_PART), .CHUNK_W(CHUNK_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .err_valid_i (err_valid),
        .err_part_i  (err_part),
        .err_chunk_i (err_chunk),
        .rd_last_i   (rd_last),
        .start_o     (start),
        .busy_o      (busy),
        .wr_fire_o   (wr_fire),
        .part_o      (part_q),
        .chunk_o     (chunk_q)
    );

    bscrub_addr_gen #(.N_PART(N_PART), .RULES(RULES)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .part_i     (part_q),
        .tbl_addr_o (tbl_addr),
        .rd_vld_o   (rd_vld),
        .rd_last_o  (rd_last)
    );

    bscrub_vec_build #(.CHUNK_W(CHUNK_W), .RULES(RULES)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start),
        .take_i  (rd_vld),
        .key_i   (chunk_q),
        .value_i (tbl_value),
        .mask_i  (tbl_mask),
        .vec_o   (vec),
        .par_o   (par)
    );

    for (genvar g = 0; g < N_PART; g++) begin : g_wen
        assign wr_en[g] = wr_fire && (part_q == IDW'(g));
    end

    assign wr_addr = chunk_q;
    assign wr_data = {par, vec};

    // R6: at most one partition RAM is written at a time
    assert_wr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R7: writes only happen inside a busy window, which closes after them
    assert_wr_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> busy);
    assert_busy_after_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |=> !busy);

    // R5: the accumulated parity agrees with the assembled bitmap
    assert_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> (wr_data[RULES] == ^wr_data[RULES-1:0]));

    // R2: the partition field of the table address holds during a repair
    assert_part_hold_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(tbl_addr[AW-1:DW])));

endmodule

// File: tb/bitmap_scrub_test.sv
module bitmap_scrub_test;

    localparam int N   = 4;
    localparam int CW  = 4;
    localparam int D   = 8;
    localparam int IDW = 2;
    localparam int DW  = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               err_valid = 1'b0;
    logic [IDW-1:0]     err_part = '0;
    logic [CW-1:0]      err_chunk = '0;
    logic [IDW+DW-1:0]  tbl_addr;
    logic [CW-1:0]      tbl_value = '0;
    logic [CW-1:0]      tbl_mask = '0;
    logic [N-1:0]       wr_en;
    logic [CW-1:0]      wr_addr;
    logic [D:0]         wr_data;
    logic               busy;

    logic [CW-1:0] tv [N*D];
    logic [CW-1:0] tm [N*D];

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [N-1:0]  en;
        logic [CW-1:0] addr;
        logic [D:0]    data;
        int            at;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        tbl_value <= tv[tbl_addr];
        tbl_mask  <= tm[tbl_addr];
    end

    bitmap_scrub #(.N_PART(N), .CHUNK_W(CW), .RULES(D)) uut (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_part(err_part),
        .err_chunk(err_chunk), .tbl_addr(tbl_addr), .tbl_value(tbl_value),
        .tbl_mask(tbl_mask), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R3 R4 R5: expected word from the matching rule
    function automatic logic [D:0] exp_word(input int p, input int ch);
        logic [D-1:0] v;
        logic pr;
        logic [CW-1:0] k;
        k = CW'(ch);
        pr = 1'b0;
        for (int r = 0; r < D; r++) begin
            v[r] = (((k ^ tv[p*D+r]) & ~tm[p*D+r]) == '0);
            pr ^= v[r];
        end
        return {pr, v};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (|wr_en)) begin
            if (q.size() == 0) begin
                check(1'b0, "R8 R9 unexpected write", longint'(wr_en), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(wr_en == e.en, "R6 wr_en", wr_en, e.en);
                check(wr_addr == e.addr, "R6 wr_addr", wr_addr, e.addr);
                check(wr_data == e.data, "R4 R5 wr_data", wr_data, e.data);
                check(cyc == e.at, "R6 write cycle", cyc, e.at);
            end
        end
    end

    // Driver: present a report, follow the scan, return at the write-cycle negedge.
    task automatic do_scrub(input int p, input int ch, input bit junk);
        exp_t e;
        int acc;
        int guard;
        @(negedge clk);
        err_valid = 1'b1;
        err_part  = IDW'(p);
        err_chunk = CW'(ch);
        acc = cyc + 1;
        e.en = N'(1) << p;
        e.addr = CW'(ch);
        e.data = exp_word(p, ch);
        e.at = acc + D + 1;
        q.push_back(e);
        for (int k = 0; k < D; k++) begin
            @(negedge clk);
            if (k == 0) begin
                if (junk) begin
                    err_part  = IDW'(p + 1);
                    err_chunk = CW'(ch + 3);
                end else begin
                    err_valid = 1'b0;
                end
            end
            check(tbl_addr == {IDW'(p), DW'(k)}, "R2 tbl_addr", tbl_addr, {IDW'(p), DW'(k)});
            check(busy == 1'b1, "R7 busy in scan", busy, 1);
        end
        guard = 0;
        while (!(|wr_en) && guard < D) begin
            @(negedge clk);
            guard++;
        end
        err_valid = 1'b0;
        check(busy == 1'b1, "R7 busy in write", busy, 1);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    initial begin
        // exact rules, no don't-care bits
        for (int i = 0; i < N*D; i++) begin
            tv[i] = CW'(i * 5 + 3);
            tm[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(wr_en == '0, "R1 wr_en at reset", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy idle", busy, 0);

        // R3 R4: exact match on one rule of partition 1
        do_scrub(1, int'(tv[1*D+2]), 1'b0);
        @(negedge clk);
        check(busy == 1'b0, "R7 busy after write", busy, 0);
        do_scrub(3, 4'hf, 1'b0);
        @(negedge clk);

        // R3: every rule fully don't-care
        for (int i = 0; i < N*D; i++) tm[i] = '1;
        do_scrub(0, 4'h9, 1'b0);
        @(negedge clk);

        // R4 R5: mixed values and masks over all partitions
        for (int i = 0; i < N*D; i++) begin
            tv[i] = CW'(i * 7 + 1);
            tm[i] = CW'((i * 3) & 4'h5);
        end
        for (int p = 0; p < N; p++) begin
            do_scrub(p, p * 5 + 2, 1'b0);
            @(negedge clk);
        end

        // R8: a different report held high for the whole repair is dropped
        do_scrub(2, 4'h6, 1'b1);
        @(negedge clk);
        check(busy == 1'b0, "R8 idle after held report", busy, 0);
        repeat (D + 4) @(negedge clk);
        check(busy == 1'b0, "R8 dropped report", busy, 0);

        // R9: same word repeated in the first cycle after its write
        do_scrub(2, 4'h5, 1'b0);
        @(negedge clk);
        err_valid = 1'b1;
        err_part  = 2'd2;
        err_chunk = 4'h5;
        @(negedge clk);
        err_valid = 1'b0;
        check(busy == 1'b0, "R9 repeat ignored", busy, 0);
        repeat (D + 4) @(negedge clk);
        check(busy == 1'b0, "R9 no late start", busy, 0);

        // R9: a different word in that cycle is accepted
        do_scrub(1, 4'hb, 1'b0);
        do_scrub(1, 4'hc, 1'b0);
        @(negedge clk);
        check(busy == 1'b0, "R7 final idle", busy, 0);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R8 pending writes", q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule